// File: doc/BRIEF.md
# Serial Port Control and Status Register Block

This block is the software-facing half of a serial port. It decodes a 32-bit, word-only register bus and holds the configuration words that a separate bit-level datapath reads. It also keeps the status flags that the datapath and software both act on. Bytes arrive from a deserializer on a valid/ready stream and are parked in a receive holding register until software reads them. Bytes that software writes leave towards a serializer on a second valid/ready stream. A single level interrupt is formed from flag/enable pairs.

Flags can be cleared in three ways: a write-one-to-clear register, a read of the receive data register, and a flush request. The datapath reports line events such as framing, parity and idle through a set-pulse vector. The receive stream cannot stall a serial line. Every cycle with `rx_valid` high is one byte that has arrived, whether or not `rx_ready` is high. `rx_ready` only tells the deserializer whether that byte will be stored; a byte offered while it is low is an overrun. The transmit stream follows normal back-pressure. `tx_valid` and `tx_data` hold steady until `tx_ready` is sampled high.

Top module: `uart_csr_top`

## Requirements
- R1: Byte offsets: config words at 0x00 (ctrl A), 0x04 (ctrl B), 0x08 (ctrl C), 0x10 (guard), 0x14 (timeout), baud divisor 0x0C, request 0x18, status 0x1C, flag clear 0x20, receive data 0x24, transmit data 0x28. Config words read back as written.
- R2: After reset all config words and both data registers read zero. Status reads 0x020000C0, which means tx-empty (bit 7) and tx-done (bit 6) are set. `irq` and `tx_valid` are low and `rx_ready` is high.
- R3: A byte offered on `rx_valid` is dropped with no status or data change unless ctrl A bit 0 (port enable) and bit 2 (receive enable) are both set.
- R4: An accepted byte that arrives while rx-full (status bit 5) is set, with ctrl C bit 12 (overrun disable) clear, sets overrun (status bit 3) and keeps the held byte. With bit 12 set, the new byte overwrites the held byte.
- R5: An accepted byte, unless it is an overrun, is stored in its full 9 bits and sets rx-full. `rx_ready` equals the inverse of rx-full.
- R6: A read of 0x24 returns the held byte zero-extended and clears rx-full. A write to 0x18 with bit 3 set also clears rx-full.
- R7: A write to 0x20 clears every status bit written as 1. Writes to 0x1C and 0x24 are ignored. 0x18 and 0x20 read zero. The baud divisor keeps only its low 16 bits.
- R8: A write to 0x28 stores 9 bits and clears tx-empty. If ctrl A bit 3 (transmit enable) is set, the byte is offered on `tx_data` with `tx_valid`, held until `tx_ready`, and on that handshake tx-empty and tx-done are set.
- R9: `irq` is high in the same cycle as any of these flag/enable pairs is true:
  - status 7 with A7, status 6 with A6, status 5 with A5, status 4 with A4, status 0 with A8
  - status 1 with C0, status 3 with A5 or C0
  - status 17 with A14, status 11 with A26, status 12 with A27, status 9 with C10, status 8 with B6, status 20 with C22, status 15 with A5
- R10: Reads of unmapped or misaligned offsets return zero, and writes to them change nothing.
- R11: `dp_evt_set` sets status bits in one cycle, except bits 3, 5, 6 and 7, which it cannot touch. A set in the same cycle as a clear of the same bit leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_ready | output | 1 | Next byte will be stored (rx-full clear) |
| rx_byte | input | DATA_W | Received byte |
| tx_valid | output | 1 | Byte offered to the serializer |
| tx_ready | input | 1 | Serializer takes the byte |
| tx_data | output | DATA_W | Byte to send |
| dp_evt_set | input | 32 | Line-event set pulses from the datapath |
| irq | output | 1 | Level interrupt |
| cfg_ctrl_a | output | 32 | Control word A |
| cfg_ctrl_b | output | 32 | Control word B |
| cfg_ctrl_c | output | 32 | Control word C |
| cfg_baud | output | 16 | Baud divisor |
| cfg_guard | output | 32 | Guard/prescale word |
| cfg_timeout | output | 32 | Receive timeout word |

## Verification
The hardest state to reach is a receive overrun. With a back-pressured stream the data source would simply wait, so the overrun depends on the rule that a byte offered while `rx_ready` is low still counts as an arrival. The stimulus enables reception, offers one byte, and offers a second byte while `rx_ready` is low. It then reads the receive register, expecting the first byte back with overrun still set. The same path, with the RXNE flag then cleared, isolates overrun on its own. That lets the bench prove that overrun reaches `irq` through either of its two enables.

// File: rtl/uart_csr_pkg.sv
package uart_csr_pkg;
  localparam int unsigned REG_W = 32;

  // byte offsets of the register map
  localparam int unsigned OFS_CTRL_A  = 'h00;
  localparam int unsigned OFS_CTRL_B  = 'h04;
  localparam int unsigned OFS_CTRL_C  = 'h08;
  localparam int unsigned OFS_BAUD    = 'h0C;
  localparam int unsigned OFS_GUARD   = 'h10;
  localparam int unsigned OFS_TMO     = 'h14;
  localparam int unsigned OFS_REQ     = 'h18;
  localparam int unsigned OFS_STATUS  = 'h1C;
  localparam int unsigned OFS_CLEAR   = 'h20;
  localparam int unsigned OFS_RXD     = 'h24;
  localparam int unsigned OFS_TXD     = 'h28;

  // plain configuration words, in slot order
  localparam int unsigned N_CFG = 6;
  localparam int unsigned CFG_OFS  [N_CFG] = '{OFS_CTRL_A, OFS_CTRL_B, OFS_CTRL_C,
                                               OFS_BAUD, OFS_GUARD, OFS_TMO};
  localparam logic [REG_W-1:0] CFG_MASK [N_CFG] = '{32'hFFFF_FFFF, 32'hFFFF_FFFF,
                                                    32'hFFFF_FFFF, 32'h0000_FFFF,
                                                    32'hFFFF_FFFF, 32'hFFFF_FFFF};
  localparam int unsigned SLOT_A = 0;
  localparam int unsigned SLOT_B = 1;
  localparam int unsigned SLOT_C = 2;
  localparam int unsigned SLOT_BAUD = 3;
  localparam int unsigned SLOT_GUARD = 4;
  localparam int unsigned SLOT_TMO = 5;

  // control bits the block itself acts on
  localparam int unsigned A_PORT_EN = 0;
  localparam int unsigned A_RX_EN   = 2;
  localparam int unsigned A_TX_EN   = 3;
  localparam int unsigned C_OVR_OFF = 12;
  localparam int unsigned REQ_FLUSH = 3;

  // status bits owned by the block
  localparam int unsigned ST_OVR     = 3;
  localparam int unsigned ST_RX_FULL = 5;
  localparam int unsigned ST_TX_DONE = 6;
  localparam int unsigned ST_TX_MT   = 7;

  localparam logic [REG_W-1:0] STATUS_RST = 32'h0200_00C0;
  localparam logic [REG_W-1:0] EVT_MASK   = ~((32'h1 << ST_OVR) | (32'h1 << ST_RX_FULL) |
                                              (32'h1 << ST_TX_DONE) | (32'h1 << ST_TX_MT));

  // interrupt pairs: status bit and enable bit in {C,B,A} (A = 0..31, B = 32.., C = 64..)
  localparam int unsigned N_PAIR = 15;
  localparam int unsigned PAIR_FLAG [N_PAIR] = '{7, 6, 5, 4, 0, 1, 3, 3, 17, 11, 12, 9, 8, 20, 15};
  localparam int unsigned PAIR_EN   [N_PAIR] = '{7, 6, 5, 4, 8, 64, 5, 64, 14, 26, 27, 74, 38, 86, 5};
endpackage

// File: rtl/uart_cfg_bank.sv
module uart_cfg_bank
  import uart_csr_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [REG_W-1:0]             wdata,
  output logic [N_CFG-1:0][REG_W-1:0]  cfg,
  output logic                         rd_hit,
  output logic [REG_W-1:0]             rd_val
);
  logic [N_CFG-1:0]            sel;
  logic [N_CFG-1:0][REG_W-1:0] masked;

  for (genvar g = 0; g < N_CFG; g++) begin : g_slot
    assign sel[g]    = (addr == ADDR_W'(CFG_OFS[g]));
    assign masked[g] = sel[g] ? (cfg[g] & CFG_MASK[g]) : '0;

    always_ff @(posedge clk) begin
      if (!rst_n)              cfg[g] <= '0;
      else if (wr_en && sel[g]) cfg[g] <= wdata & CFG_MASK[g];
    end
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < N_CFG; i++) rd_val = rd_val | masked[i];
  end
  assign rd_hit = |sel;
endmodule

// File: rtl/uart_flag_unit.sv
module uart_flag_unit
  import uart_csr_pkg::*;
#(
  parameter int unsigned DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_W-1:0]  ctrl_a,
  input  logic [REG_W-1:0]  ctrl_c,
  input  logic              clr_wr,
  input  logic              flush_wr,
  input  logic              pop_rd,
  input  logic              txd_wr,
  input  logic [REG_W-1:0]  wdata,
  input  logic [REG_W-1:0]  evt_set,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              tx_ready,
  output logic [REG_W-1:0]  status,
  output logic [DATA_W-1:0] rx_hold,
  output logic [DATA_W-1:0] tx_hold,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  output logic              rx_ready
);
  logic             rx_on, arrive, ovr_hit, store, tx_fire, tx_start;
  logic [REG_W-1:0] status_d;

  assign rx_on    = ctrl_a[A_PORT_EN] & ctrl_a[A_RX_EN];
  assign arrive   = rx_valid & rx_on;
  assign ovr_hit  = arrive & status[ST_RX_FULL] & ~ctrl_c[C_OVR_OFF];
  assign store    = arrive & ~ovr_hit;
  assign tx_fire  = tx_valid & tx_ready;
  assign tx_start = txd_wr & ctrl_a[A_TX_EN] & ~tx_valid;
  assign rx_ready = ~status[ST_RX_FULL];

  // clears first, then sets: a set in the same cycle wins
  always_comb begin
    status_d = status;
    if (clr_wr)               status_d = status_d & ~wdata;
    if (flush_wr && wdata[REQ_FLUSH]) status_d[ST_RX_FULL] = 1'b0;
    if (pop_rd)               status_d[ST_RX_FULL] = 1'b0;
    if (txd_wr)               status_d[ST_TX_MT] = 1'b0;
    if (tx_fire) begin
      status_d[ST_TX_MT]   = 1'b1;
      status_d[ST_TX_DONE] = 1'b1;
    end
    if (store)                status_d[ST_RX_FULL] = 1'b1;
    if (ovr_hit)              status_d[ST_OVR] = 1'b1;
    status_d = status_d | (evt_set & EVT_MASK);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status   <= STATUS_RST;
      rx_hold  <= '0;
      tx_hold  <= '0;
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      status <= status_d;
      if (store)  rx_hold <= rx_byte;
      if (txd_wr) tx_hold <= wdata[DATA_W-1:0];
      if (tx_start) begin
        tx_valid <= 1'b1;
        tx_data  <= wdata[DATA_W-1:0];
      end else if (tx_fire) begin
        tx_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uart_irq_merge.sv
module uart_irq_merge
  import uart_csr_pkg::*;
(
  input  logic [REG_W-1:0] status,
  input  logic [REG_W-1:0] ctrl_a,
  input  logic [REG_W-1:0] ctrl_b,
  input  logic [REG_W-1:0] ctrl_c,
  output logic             irq
);
  logic [3*REG_W-1:0] enables;
  logic [N_PAIR-1:0]  hit;

  assign enables = {ctrl_c, ctrl_b, ctrl_a};

  for (genvar p = 0; p < N_PAIR; p++) begin : g_pair
    assign hit[p] = status[PAIR_FLAG[p]] & enables[PAIR_EN[p]];
  end

  assign irq = |hit;
endmodule

// File: rtl/uart_csr_top.sv
module uart_csr_top
  import uart_csr_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_byte,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  input  logic [31:0]       dp_evt_set,
  output logic              irq,
  output logic [31:0]       cfg_ctrl_a,
  output logic [31:0]       cfg_ctrl_b,
  output logic [31:0]       cfg_ctrl_c,
  output logic [15:0]       cfg_baud,
  output logic [31:0]       cfg_guard,
  output logic [31:0]       cfg_timeout
);
  logic                        wr, rd;
  logic                        cfg_hit;
  logic [REG_W-1:0]            cfg_val;
  logic [N_CFG-1:0][REG_W-1:0] cfg;
  logic [REG_W-1:0]            status_q;
  logic [DATA_W-1:0]           rx_hold_q, tx_hold_q;

  assign wr = bus_en &  bus_we;
  assign rd = bus_en & ~bus_we;

  uart_cfg_bank #(.ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr), .addr(bus_addr), .wdata(bus_wdata),
    .cfg(cfg), .rd_hit(cfg_hit), .rd_val(cfg_val)
  );

  uart_flag_unit #(.DATA_W(DATA_W)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .ctrl_a(cfg[SLOT_A]), .ctrl_c(cfg[SLOT_C]),
    .clr_wr(wr && bus_addr == ADDR_W'(OFS_CLEAR)),
    .flush_wr(wr && bus_addr == ADDR_W'(OFS_REQ)),
    .pop_rd(rd && bus_addr == ADDR_W'(OFS_RXD)),
    .txd_wr(wr && bus_addr == ADDR_W'(OFS_TXD)),
    .wdata(bus_wdata), .evt_set(dp_evt_set),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_ready(tx_ready),
    .status(status_q), .rx_hold(rx_hold_q), .tx_hold(tx_hold_q),
    .tx_valid(tx_valid), .tx_data(tx_data), .rx_ready(rx_ready)
  );

  uart_irq_merge u_irq (
    .status(status_q), .ctrl_a(cfg[SLOT_A]), .ctrl_b(cfg[SLOT_B]),
    .ctrl_c(cfg[SLOT_C]), .irq(irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      if (cfg_hit)                                 bus_rdata = cfg_val;
      else if (bus_addr == ADDR_W'(OFS_STATUS))   bus_rdata = status_q;
      else if (bus_addr == ADDR_W'(OFS_RXD))      bus_rdata = REG_W'(rx_hold_q);
      else if (bus_addr == ADDR_W'(OFS_TXD))      bus_rdata = REG_W'(tx_hold_q);
    end
  end

  assign cfg_ctrl_a  = cfg[SLOT_A];
  assign cfg_ctrl_b  = cfg[SLOT_B];
  assign cfg_ctrl_c  = cfg[SLOT_C];
  assign cfg_baud    = cfg[SLOT_BAUD][15:0];
  assign cfg_guard   = cfg[SLOT_GUARD];
  assign cfg_timeout = cfg[SLOT_TMO];
endmodule

// File: rtl/uart_csr_chk.sv
module uart_csr_chk #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [DATA_W-1:0] tx_data,
  input logic [31:0]       dp_evt_set,
  input logic              irq,
  input logic [31:0]       cfg_ctrl_a,
  input logic [31:0]       cfg_ctrl_b,
  input logic [31:0]       cfg_ctrl_c,
  input logic [31:0]       status,
  input logic [DATA_W-1:0] rx_hold
);
  logic rx_on;
  assign rx_on = cfg_ctrl_a[0] & cfg_ctrl_a[2];

  AST_RX_DROP_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_on && !bus_en && dp_evt_set == '0 && !tx_valid)
    |=> ($stable(status) && $stable(rx_hold))); // R3

  AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_on && !rx_ready && !cfg_ctrl_c[12])
    |=> (status[3] && $stable(rx_hold))); // R4

  AST_POP_FREES_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && bus_addr == ADDR_W'('h24) && !rx_valid)
    |=> rx_ready); // R6

  AST_TX_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R8

  AST_TX_DONE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (status[7] && status[6] && !tx_valid)); // R8

  AST_IRQ_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ctrl_a == '0 && cfg_ctrl_b == '0 && cfg_ctrl_c == '0) |-> !irq); // R9
endmodule

bind uart_csr_top uart_csr_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .dp_evt_set(dp_evt_set), .irq(irq),
  .cfg_ctrl_a(cfg_ctrl_a), .cfg_ctrl_b(cfg_ctrl_b), .cfg_ctrl_c(cfg_ctrl_c),
  .status(status_q), .rx_hold(rx_hold_q)
);

// File: tb/uart_csr_top_tb_top.sv
`timescale 1ns/1ps
module uart_csr_top_tb_top;
  localparam int unsigned ADDR_W = 10;
  localparam int unsigned DATA_W = 9;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_en = 1'b0, bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0, bus_rdata;
  logic              rx_valid = 1'b0, rx_ready;
  logic [DATA_W-1:0] rx_byte = '0;
  logic              tx_valid, tx_ready = 1'b0;
  logic [DATA_W-1:0] tx_data;
  logic [31:0]       dp_evt_set = '0;
  logic              irq;
  logic [31:0]       cfg_ctrl_a, cfg_ctrl_b, cfg_ctrl_c, cfg_guard, cfg_timeout;
  logic [15:0]       cfg_baud;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  uart_csr_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_byte(rx_byte), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .dp_evt_set(dp_evt_set), .irq(irq), .cfg_ctrl_a(cfg_ctrl_a), .cfg_ctrl_b(cfg_ctrl_b),
    .cfg_ctrl_c(cfg_ctrl_c), .cfg_baud(cfg_baud), .cfg_guard(cfg_guard),
    .cfg_timeout(cfg_timeout)
  );

  typedef struct packed {
    logic        wr;
    logic [9:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 10'h01C, 32'h0,          32'h0200_00C0}, // R2 status reset
    '{1'b0, 10'h000, 32'h0,          32'h0},         // R2 ctrl A reset
    '{1'b0, 10'h024, 32'h0,          32'h0},         // R2 rx data reset
    '{1'b0, 10'h028, 32'h0,          32'h0},         // R2 tx data reset
    '{1'b1, 10'h004, 32'hDEAD_BEEF,  32'h0},         // R1
    '{1'b0, 10'h004, 32'h0,          32'hDEAD_BEEF}, // R1
    '{1'b1, 10'h010, 32'h0000_A55A,  32'h0},         // R1
    '{1'b0, 10'h010, 32'h0,          32'h0000_A55A}, // R1
    '{1'b1, 10'h014, 32'h1234_5678,  32'h0},         // R1
    '{1'b0, 10'h014, 32'h0,          32'h1234_5678}, // R1
    '{1'b1, 10'h00C, 32'h1234_ABCD,  32'h0},         // R7 baud
    '{1'b0, 10'h00C, 32'h0,          32'h0000_ABCD}, // R7 baud
    '{1'b1, 10'h018, 32'hFFFF_FFF7,  32'h0},         // R7 request
    '{1'b0, 10'h018, 32'h0,          32'h0},         // R7 request reads zero
    '{1'b0, 10'h020, 32'h0,          32'h0},         // R7 clear reads zero
    '{1'b1, 10'h01C, 32'h0000_0000,  32'h0},         // R7 status write ignored
    '{1'b1, 10'h024, 32'h0000_01FF,  32'h0},         // R7 rx data write ignored
    '{1'b0, 10'h01C, 32'h0,          32'h0200_00C0}, // R7
    '{1'b0, 10'h024, 32'h0,          32'h0},         // R7
    '{1'b1, 10'h02C, 32'hFFFF_FFFF,  32'h0},         // R10 unmapped write
    '{1'b0, 10'h02C, 32'h0,          32'h0},         // R10 unmapped read
    '{1'b0, 10'h005, 32'h0,          32'h0}          // R10 misaligned read
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic bus_write(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  task automatic rx_push(input logic [8:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic evt_pulse(input logic [31:0] m);
    @(negedge clk);
    dp_evt_set = m;
    @(negedge clk);
    dp_evt_set = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset();
    // R2 reset state at the ports
    #1;
    check({29'b0, irq, tx_valid, rx_ready}, 32'h1, "R2 irq/tx_valid/rx_ready");

    // vector table walk
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) bus_write(VECS[i].addr, VECS[i].data);
      else begin
        bus_read(VECS[i].addr, rv);
        check(rv, VECS[i].exp, $sformatf("vector %0d (R1 R2 R7 R10)", i));
      end
    end

    // R3: receive disabled drops bytes
    do_reset();
    bus_write(10'h000, 32'h1);
    rx_push(9'h0AA);
    bus_read(10'h01C, rv); check(rv, 32'h0200_00C0, "R3 status after dropped byte");
    bus_read(10'h024, rv); check(rv, 32'h0, "R3 rx data after dropped byte");

    // R5 / R6: store, ready, pop
    bus_write(10'h000, 32'h5);
    rx_push(9'h1A5);
    check({31'b0, rx_ready}, 32'h0, "R5 rx_ready low when full");
    bus_read(10'h01C, rv); check(rv, 32'h0200_00E0, "R5 rx-full set");
    bus_read(10'h024, rv); check(rv, 32'h0000_01A5, "R6 read returns 9-bit byte");
    bus_read(10'h01C, rv); check(rv, 32'h0200_00C0, "R6 read cleared rx-full");
    check({31'b0, rx_ready}, 32'h1, "R5 rx_ready high again");

    // R4: overrun keeps old byte, R7 clears it
    rx_push(9'h011);
    rx_push(9'h022);
    bus_read(10'h01C, rv); check(rv, 32'h0200_00E8, "R4 overrun flag");
    bus_read(10'h024, rv); check(rv, 32'h0000_0011, "R4 held byte kept");
    bus_write(10'h020, 32'h8);
    bus_read(10'h01C, rv); check(rv, 32'h0200_00C0, "R7 clear overrun");

    // R4 with overrun disabled, R6 flush request
    bus_write(10'h008, 32'h0000_1000);
    rx_push(9'h033);
    rx_push(9'h044);
    bus_read(10'h01C, rv); check(rv, 32'h0200_00E0, "R4 no overrun when disabled");
    bus_write(10'h018, 32'h8);
    bus_read(10'h01C, rv); check(rv, 32'h0200_00C0, "R6 flush cleared rx-full");
    bus_read(10'h024, rv); check(rv, 32'h0000_0044, "R4 overwrite kept newest");

    // R8: transmit
    do_reset();
    bus_write(10'h000, 32'h1);
    bus_write(10'h028, 32'h0C3);
    check({31'b0, tx_valid}, 32'h0, "R8 no offer without tx enable");
    bus_read(10'h01C, rv); check(rv, 32'h0200_0040, "R8 tx-empty cleared");
    bus_read(10'h028, rv); check(rv, 32'h0000_00C3, "R8 tx data readback");
    bus_write(10'h000, 32'h9);
    bus_write(10'h020, 32'h40);
    bus_write(10'h028, 32'h05A);
    check({23'b0, tx_valid, tx_data}, {23'b0, 1'b1, 9'h05A}, "R8 byte offered");
    repeat (2) @(negedge clk);
    check({23'b0, tx_valid, tx_data}, {23'b0, 1'b1, 9'h05A}, "R8 byte held under back-pressure");
    bus_read(10'h01C, rv); check(rv, 32'h0200_0000, "R8 flags while sending");
    @(negedge clk); tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
    check({31'b0, tx_valid}, 32'h0, "R8 offer dropped after handshake");
    bus_read(10'h01C, rv); check(rv, 32'h0200_00C0, "R8 tx-empty and tx-done set");

    // R9: interrupt pairs
    do_reset();
    bus_write(10'h000, 32'h80);
    #1 check({31'b0, irq}, 32'h1, "R9 tx-empty with A7");
    bus_write(10'h000, 32'h0);
    #1 check({31'b0, irq}, 32'h0, "R9 all enables off");
    evt_pulse(32'h2);
    #1 check({31'b0, irq}, 32'h0, "R9 framing flag without C0");
    bus_write(10'h008, 32'h1);
    #1 check({31'b0, irq}, 32'h1, "R9 framing flag with C0");
    bus_write(10'h020, 32'h2);
    #1 check({31'b0, irq}, 32'h0, "R9 drops when flag cleared");
    bus_write(10'h008, 32'h0);
    bus_write(10'h000, 32'h5);
    rx_push(9'h001);
    rx_push(9'h002);
    bus_read(10'h024, rv);
    #1 check({31'b0, irq}, 32'h0, "R9 overrun alone, enables off");
    bus_write(10'h000, 32'h25);
    #1 check({31'b0, irq}, 32'h1, "R9 overrun with A5");
    bus_write(10'h000, 32'h5);
    bus_write(10'h008, 32'h1);
    #1 check({31'b0, irq}, 32'h1, "R9 overrun with C0");
    bus_write(10'h008, 32'h0);
    bus_write(10'h020, 32'h8);
    evt_pulse(32'h8000);
    #1 check({31'b0, irq}, 32'h0, "R9 bit15 flag without A5");
    bus_write(10'h000, 32'h20);
    #1 check({31'b0, irq}, 32'h1, "R9 bit15 flag with A5");

    // R11: event input mask and set-wins
    do_reset();
    evt_pulse(32'hFFFF_FFFF);
    bus_read(10'h01C, rv); check(rv, 32'hFFFF_FFD7, "R11 event mask");
    check({31'b0, rx_ready}, 32'h1, "R11 event cannot fill rx");
    bus_write(10'h020, 32'hFFFF_FFFF);
    bus_read(10'h01C, rv); check(rv, 32'h0, "R7 clear all bits");
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = 10'h020; bus_wdata = 32'h1; dp_evt_set = 32'h1;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; bus_wdata = '0; dp_evt_set = '0;
    bus_read(10'h01C, rv); check(rv, 32'h1, "R11 set wins over clear");

    finish_run();
  end
endmodule